// File: doc/BRIEF.md
# Printer Output Mirror Capture Buffer

This block listens, without taking part, to the write channel between the processor and a console printer adapter. Every time the snooped write strobe rises, the block copies the data word present on the write bus into a deep first-in first-out buffer. It has no outputs on the device side, so it cannot drive, stall or alter the real printer path. Each write carries one typewriter character code in its upper byte, and the lower byte is zero.

A host link drains the buffer through a request/response pair of valid/ready channels. Each accepted request pops at most one word. It produces exactly one response, which is either one captured word flagged as data or a zero word flagged as empty. A push-side state machine and a pop-side state machine coordinate with the buffer's write-acknowledge and not-empty status. A sticky overflow flag records a capture that was dropped because the buffer was full, and the host clears it with a pulse.

Back-pressure rules:
- Only one request is outstanding at a time. The request ready output is low from the accepting edge until the response is taken.
- The response stays valid, with stable data and status, until the host raises response ready.

Top module: `mirror_capture_fifo`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `ovf_flag` is 0.
- R2: Each low-to-high transition of `snoop_stb` stores exactly one word. A strobe that stays high for several cycles stores one word only.
- R3: Responses return the captured 16-bit words unchanged and in capture order, one word per response. A zero word that was captured is returned with `rsp_has_data` = 1.
- R4: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is 1 in the cycle after acceptance, and `req_ready` is 0 while a response is pending.
- R5: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_data` and `rsp_has_data` hold their values.
- R6: A request that finds the buffer empty gets a response with `rsp_has_data` = 0 and `rsp_data` = 0. Nothing is removed.
- R7: The buffer holds DEPTH words (1024 by default). A capture that arrives while it is full is dropped and leaves the stored words intact.
- R8: A dropped capture sets `ovf_flag`. The flag stays 1 until a cycle with `ovf_clear` = 1 clears it, and a new drop takes precedence over a clear in the same cycle.
- R9: A capture and a pop on the same clock edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snoop_stb | input | 1 | Snooped device write strobe |
| snoop_data | input | 16 | Snooped device write data |
| req_valid | input | 1 | Host read request valid |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 16 | Popped word, or zero when empty |
| rsp_has_data | output | 1 | 1 = data word, 0 = buffer was empty |
| ovf_flag | output | 1 | Sticky dropped-capture flag |
| ovf_clear | input | 1 | Clears the overflow flag |

## Verification
An error in the pointers or the occupancy count shows up on the next response. The symptom is a word out of order, a repeated word, or an empty indication while words remain. A push-side state machine that misses edges or captures the same edge twice shows up as a missing or duplicated character within two pops. A pop-side state machine that loses track of its pending response shows `req_ready` and `rsp_valid` high together, or a response that changes while it is being held, in the very cycle the fault occurs.

// File: rtl/mirror_pkg.sv
package mirror_pkg;
  typedef enum logic {PUSH_IDLE, PUSH_WAIT} push_state_t;
  typedef enum logic {POP_IDLE, POP_HOLD} pop_state_t;
endpackage

// File: rtl/mirror_push_ctl.sv
module mirror_push_ctl
  import mirror_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [DATA_W-1:0] data,
  input  logic              wr_ack,
  input  logic              wr_nack,
  input  logic              ovf_clear,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              ovf
);
  push_state_t state;
  logic        stb_q;
  logic        rise;

  assign rise    = stb && !stb_q;
  assign wr_en   = rise && (state == PUSH_IDLE);
  assign wr_data = data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      state <= PUSH_IDLE;
      ovf   <= 1'b0;
    end else begin
      stb_q <= stb;
      case (state)
        PUSH_IDLE: if (wr_en) state <= PUSH_WAIT;
        PUSH_WAIT: if (wr_ack || wr_nack) state <= PUSH_IDLE;
        default:   state <= PUSH_IDLE;
      endcase
      if (state == PUSH_WAIT && wr_nack) ovf <= 1'b1;
      else if (ovf_clear)                ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/mirror_sync_fifo.sv
module mirror_sync_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              not_empty,
  output logic              wr_ack,
  output logic              wr_nack
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [CW-1:0]     cnt;
  logic              do_wr, do_rd;

  assign not_empty = (cnt != '0);
  assign do_wr     = wr_en && (cnt != FULL);
  assign do_rd     = rd_en && not_empty;
  assign rd_data   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      wr_ack  <= 1'b0;
      wr_nack <= 1'b0;
    end else begin
      wr_ack  <= do_wr;
      wr_nack <= wr_en && !do_wr;
      if (do_wr) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/mirror_pop_ctl.sv
module mirror_pop_ctl
  import mirror_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_has_data,
  input  logic              fifo_valid,
  input  logic [DATA_W-1:0] fifo_dout,
  output logic              fifo_rd
);
  pop_state_t state;
  logic       accept;

  assign req_ready = (state == POP_IDLE);
  assign rsp_valid = (state == POP_HOLD);
  assign accept    = req_ready && req_valid;
  assign fifo_rd   = accept && fifo_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= POP_IDLE;
      rsp_data     <= '0;
      rsp_has_data <= 1'b0;
    end else begin
      case (state)
        POP_IDLE: if (accept) begin
          state        <= POP_HOLD;
          rsp_has_data <= fifo_valid;
          rsp_data     <= fifo_valid ? fifo_dout : '0;
        end
        POP_HOLD: if (rsp_ready) state <= POP_IDLE;
        default:  state <= POP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mirror_capture_fifo.sv
module mirror_capture_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snoop_stb,
  input  logic [DATA_W-1:0] snoop_data,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_has_data,
  output logic              ovf_flag,
  input  logic              ovf_clear
);
  logic              wr_en, rd_en, fvalid, wr_ack, wr_nack;
  logic [DATA_W-1:0] wr_data, fdout;

  mirror_push_ctl #(.DATA_W(DATA_W)) u_push (
    .clk(clk), .rst_n(rst_n), .stb(snoop_stb), .data(snoop_data),
    .wr_ack(wr_ack), .wr_nack(wr_nack), .ovf_clear(ovf_clear),
    .wr_en(wr_en), .wr_data(wr_data), .ovf(ovf_flag)
  );

  mirror_sync_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(fdout), .not_empty(fvalid),
    .wr_ack(wr_ack), .wr_nack(wr_nack)
  );

  mirror_pop_ctl #(.DATA_W(DATA_W)) u_pop (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_has_data(rsp_has_data), .fifo_valid(fvalid), .fifo_dout(fdout),
    .fifo_rd(rd_en)
  );
endmodule

// File: rtl/mirror_capture_checker.sv
module mirror_capture_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_has_data,
  input logic              ovf_flag,
  input logic              ovf_clear
);
  assert_one_outstanding_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && req_ready));

  assert_rsp_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_rsp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_has_data)));

  assert_empty_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_has_data) |-> (rsp_data == '0));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clear) |=> ovf_flag);
endmodule

bind mirror_capture_fifo mirror_capture_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .rsp_has_data(rsp_has_data), .ovf_flag(ovf_flag), .ovf_clear(ovf_clear)
);

// File: tb/mirror_capture_fifo_bench.sv
module mirror_capture_fifo_bench;
  localparam int DEPTH = 1024;
  // vector: {is_push, data[15:0], exp_has, exp_data[15:0]}
  localparam int NV = 12;
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 16'h9A00, 1'b0, 16'h0000},
    {1'b1, 16'h2100, 1'b0, 16'h0000},
    {1'b0, 16'h0000, 1'b1, 16'h9A00},
    {1'b1, 16'h4100, 1'b0, 16'h0000},
    {1'b0, 16'h0000, 1'b1, 16'h2100},
    {1'b0, 16'h0000, 1'b1, 16'h4100},
    {1'b0, 16'h0000, 1'b0, 16'h0000},
    {1'b1, 16'h9200, 1'b0, 16'h0000},
    {1'b1, 16'h0000, 1'b0, 16'h0000},
    {1'b0, 16'h0000, 1'b1, 16'h9200},
    {1'b0, 16'h0000, 1'b1, 16'h0000},
    {1'b0, 16'h0000, 1'b0, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        snoop_stb = 1'b0;
  logic [15:0] snoop_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic        rsp_has_data;
  logic        ovf_flag;
  logic        ovf_clear = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  mirror_capture_fifo #(.DATA_W(16), .DEPTH(DEPTH)) u_mirror_capture_fifo (
    .clk(clk), .rst_n(rst_n), .snoop_stb(snoop_stb), .snoop_data(snoop_data),
    .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_has_data(rsp_has_data),
    .ovf_flag(ovf_flag), .ovf_clear(ovf_clear)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] d, input int hold);
    @(negedge clk);
    snoop_data = d;
    snoop_stb  = 1'b1;
    repeat (hold) @(negedge clk);
    snoop_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic pop(input logic exp_has, input logic [15:0] exp_d, input string tag);
    @(negedge clk);
    rsp_ready = 1'b1;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1 && req_ready === 1'b0, {tag, " R4 rsp_valid/req_ready"},
        {30'd0, rsp_valid, req_ready}, 32'h2);
    chk(rsp_has_data === exp_has && rsp_data === exp_d, {tag, " has/data"},
        {15'd0, rsp_has_data, rsp_data}, {15'd0, exp_has, exp_d});
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && ovf_flag === 1'b0, "R1 reset outputs",
        {29'd0, req_ready, rsp_valid, ovf_flag}, 32'h4);

    // R3 R6 vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][33]) push(VEC[i][32:17], 1);
      else pop(VEC[i][16], VEC[i][15:0], "R3/R6 vector");
    end

    // R2 long strobe pushes once
    push(16'hC300, 6);
    pop(1'b1, 16'hC300, "R2 long strobe word");
    pop(1'b0, 16'h0000, "R2 no duplicate");

    // R5 hold while rsp_ready low
    push(16'h5A00, 1);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(rsp_valid === 1'b1 && req_ready === 1'b0 && rsp_data === 16'h5A00 && rsp_has_data === 1'b1,
        "R5 held response", {14'd0, rsp_valid, req_ready, rsp_data}, {14'd0, 2'b10, 16'h5A00});
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R4 released after take",
        {30'd0, rsp_valid, req_ready}, 32'h1);
    pop(1'b0, 16'h0000, "R6 empty after hold");

    // R9 simultaneous push and pop
    push(16'h1100, 1);
    @(negedge clk);
    snoop_data = 16'h2200;
    snoop_stb  = 1'b1;
    req_valid  = 1'b1;
    @(negedge clk);
    snoop_stb = 1'b0;
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1 && rsp_data === 16'h1100, "R9 pop during push",
        {15'd0, rsp_valid, rsp_data}, {15'd0, 1'b1, 16'h1100});
    @(negedge clk);
    pop(1'b1, 16'h2200, "R9 pushed word kept");
    pop(1'b0, 16'h0000, "R9 then empty");

    // R7 R8 fill, overflow, clear
    for (int i = 0; i < DEPTH; i++) push(16'(i * 3 + 1), 1);
    chk(ovf_flag === 1'b0, "R7 full without drop", {31'd0, ovf_flag}, 32'h0);
    push(16'hEEEE, 1);
    chk(ovf_flag === 1'b1, "R8 flag set on drop", {31'd0, ovf_flag}, 32'h1);
    repeat (4) @(negedge clk);
    chk(ovf_flag === 1'b1, "R8 flag sticky", {31'd0, ovf_flag}, 32'h1);
    ovf_clear = 1'b1;
    @(negedge clk);
    ovf_clear = 1'b0;
    chk(ovf_flag === 1'b0, "R8 flag cleared", {31'd0, ovf_flag}, 32'h0);
    for (int i = 0; i < DEPTH; i++) pop(1'b1, 16'(i * 3 + 1), "R7 drain order");
    pop(1'b0, 16'h0000, "R7 dropped word absent");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule